// File: doc/BRIEF.md
# Pulse-Mark Infrared Frame Transmitter

The block sends a zero-terminated byte message as a pulse pattern on one infrared drive line. Each bit occupies a fixed slot: for a programmable number of ticks the line carries the bit value, then it is held low for a second programmable number of ticks. A `0` bit therefore shows no pulse, only idle time. Bytes go out most significant bit first. They are read from an external message buffer through a combinational address/data port, starting at address 0.

After the last byte the line stays low for a quiet gap. The whole frame, including its gap, is then sent again, up to a programmable repeat count. A tick lasts `20 + 5*sample` clock periods. The timing registers are written through a small select/data port. Their values are captured when a send is accepted, so the running frame keeps one consistent set of timings.

A start request is refused when a send is already running or when an external receiver reports activity. A one-bit status output shows whether the most recent request was refused.

Top module: `ir_frame_tx`

## Requirements
- R1: One tick lasts 20 + 5*sample clock periods, and every mark, space and gap phase lasts a whole number of ticks.
- R2: Bits of each byte are sent MSB first. For each bit, `ir_o` equals the bit for `mark` ticks and is then low for `space` ticks.
- R3: Bytes are read from `msg_addr_o` = 0, 1, 2, ... A byte of value 0 ends the frame and is not sent. A frame whose first byte is 0 consists of the quiet gap alone.
- R4: When the address passes the last buffer location (2^AW bytes sent) without finding a zero byte, the frame ends as if a zero byte had been read.
- R5: After the last byte of each copy, `ir_o` is held low for `gap` ticks.
- R6: The frame, each copy followed by its gap, is sent `repeat` times back to back. A `repeat` of 0 sends one copy.
- R7: A `start_i` sampled while idle with `rx_active_i` low is accepted, and `status_o` becomes 0. A `start_i` sampled while busy or while `rx_active_i` is high is refused, and `status_o` becomes 1. A refused request does not change the frame in progress.
- R8: `busy_o` rises in the cycle after an accepted start. It falls one cycle after the last gap cycle of the last copy. `ir_o` is low whenever `busy_o` is low and during reset.
- R9: Register select codes are 0 sample, 1 mark, 2 space, 3 gap and 4 repeat. Reset values are sample 2, mark 20, space 20, gap 100 and repeat 3.
- R10: Register values are captured at an accepted start. Writes made while busy do not affect the frame in progress.
- R11: A mark, space or gap length of 0 is treated as 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select (R9 codes) |
| cfg_wdata_i | input | 8 | Register write data |
| start_i | input | 1 | Send request |
| rx_active_i | input | 1 | Receiver activity, blocks a start |
| msg_addr_o | output | AW (4) | Message buffer read address |
| msg_data_i | input | 8 | Message byte at `msg_addr_o`, same cycle |
| ir_o | output | 1 | Infrared drive line |
| busy_o | output | 1 | Send in progress |
| status_o | output | 1 | 1 if the most recent request was refused |

## Verification
A new start request can arrive in the same cycle that the final gap of the last copy expires. `busy_o` is still high in that cycle, so the request must be refused. The bench provokes this by raising `start_i` for exactly the last gap cycle. It then expects `status_o` to be 1, `busy_o` to fall in the next cycle and no new pulse to follow. Another request lands mid-frame together with a write to the mark register. The bench judges this one by comparing the full waveform against the original timing.

// File: rtl/ir_tx_pkg.sv
`timescale 1ns/1ps
package ir_tx_pkg;
  localparam int CFG_W = 8;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic [CFG_W-1:0] smp;
    logic [CFG_W-1:0] mark;
    logic [CFG_W-1:0] space;
    logic [CFG_W-1:0] gap;
    logic [CFG_W-1:0] rep;
  } ir_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_MARK, ST_SPACE, ST_GAP} ir_state_e;

  localparam logic [SEL_W-1:0] SEL_SMP   = 3'd0;
  localparam logic [SEL_W-1:0] SEL_MARK  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_SPACE = 3'd2;
  localparam logic [SEL_W-1:0] SEL_GAP   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_REP   = 3'd4;

  localparam ir_cfg_t CFG_RST = '{smp: 8'd2, mark: 8'd20, space: 8'd20, gap: 8'd100, rep: 8'd3};
endpackage

// File: rtl/ir_cfg_regs.sv
`timescale 1ns/1ps
module ir_cfg_regs
  import ir_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CFG_W-1:0] wdata_i,
  output ir_cfg_t          cfg_o
);
  ir_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
    end else if (we_i) begin
      case (sel_i)
        SEL_SMP:   cfg_q.smp   <= wdata_i;
        SEL_MARK:  cfg_q.mark  <= wdata_i;
        SEL_SPACE: cfg_q.space <= wdata_i;
        SEL_GAP:   cfg_q.gap   <= wdata_i;
        SEL_REP:   cfg_q.rep   <= wdata_i;
        default:   ;
      endcase
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/ir_tick_gen.sv
`timescale 1ns/1ps
module ir_tick_gen #(
  parameter int SMP_W = 8,
  parameter int BASE  = 20,
  parameter int STEP  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic             tick_o
);
  localparam int MAX_LEN = BASE + STEP * (2**SMP_W - 1);
  localparam int CW      = $clog2(MAX_LEN + 1);

  logic [CW-1:0] len, cnt_q;
  logic          wrap;

  assign len    = CW'(BASE) + CW'(STEP) * CW'(smp_i);
  assign wrap   = (cnt_q == len - 1'b1);
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (restart_i)   cnt_q <= '0;
    else if (run_i)       cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ir_phase_timer.sv
`timescale 1ns/1ps
module ir_phase_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] len_i,   // >= 1
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q;

  assign done_o = tick_i && (cnt_q == len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ir_frame_tx.sv
`timescale 1ns/1ps
module ir_frame_tx
  import ir_tx_pkg::*;
#(
  parameter int AW        = 4,
  parameter int DW        = 8,
  parameter int TICK_BASE = 20,
  parameter int TICK_STEP = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             start_i,
  input  logic             rx_active_i,
  output logic [AW-1:0]    msg_addr_o,
  input  logic [DW-1:0]    msg_data_i,
  output logic             ir_o,
  output logic             busy_o,
  output logic             status_o
);
  localparam int BCW = $clog2(DW);

  ir_cfg_t   cfg, snap_q;
  ir_state_e state_q;
  logic [AW:0]      addr_q;
  logic [DW-1:0]    shift_q;
  logic [BCW-1:0]   bit_q;
  logic [CFG_W-1:0] rep_q;
  logic [CFG_W-1:0] ph_len;
  logic             status_q;
  logic             byte_ok, accept, tick, done, restart, run;

  function automatic logic [CFG_W-1:0] at_least_one(input logic [CFG_W-1:0] v);
    return (v == '0) ? CFG_W'(1) : v;
  endfunction

  ir_cfg_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  assign run     = (state_q != ST_IDLE);
  assign byte_ok = !addr_q[AW] && (msg_data_i != '0);
  assign accept  = start_i && !run && !rx_active_i;
  assign restart = accept || done;

  always_comb begin
    case (state_q)
      ST_MARK:  ph_len = at_least_one(snap_q.mark);
      ST_SPACE: ph_len = at_least_one(snap_q.space);
      ST_GAP:   ph_len = at_least_one(snap_q.gap);
      default:  ph_len = CFG_W'(1);
    endcase
  end

  ir_tick_gen #(
    .SMP_W (CFG_W),
    .BASE  (TICK_BASE),
    .STEP  (TICK_STEP)
  ) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .run_i     (run),
    .smp_i     (snap_q.smp),
    .tick_o    (tick)
  );

  ir_phase_timer #(.LEN_W(CFG_W)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .tick_i    (tick),
    .len_i     (ph_len),
    .done_o    (done)
  );

  // Frame sequencer: next byte is looked up in the same cycle a slot ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      snap_q   <= CFG_RST;
      addr_q   <= '0;
      shift_q  <= '0;
      bit_q    <= '0;
      rep_q    <= '0;
      status_q <= 1'b0;
    end else begin
      if (start_i) status_q <= !accept;
      case (state_q)
        ST_IDLE: if (accept) begin
          snap_q <= cfg;
          rep_q  <= at_least_one(cfg.rep);
          if (byte_ok) begin
            shift_q <= msg_data_i;
            bit_q   <= BCW'(DW - 1);
            addr_q  <= addr_q + 1'b1;
            state_q <= ST_MARK;
          end else begin
            addr_q  <= '0;
            state_q <= ST_GAP;
          end
        end
        ST_MARK: if (done) state_q <= ST_SPACE;
        ST_SPACE: if (done) begin
          if (bit_q != '0) begin
            shift_q <= shift_q << 1;
            bit_q   <= bit_q - 1'b1;
            state_q <= ST_MARK;
          end else if (byte_ok) begin
            shift_q <= msg_data_i;
            bit_q   <= BCW'(DW - 1);
            addr_q  <= addr_q + 1'b1;
            state_q <= ST_MARK;
          end else begin
            addr_q  <= '0;
            state_q <= ST_GAP;
          end
        end
        ST_GAP: if (done) begin
          if (rep_q > CFG_W'(1)) begin
            rep_q <= rep_q - 1'b1;
            if (byte_ok) begin
              shift_q <= msg_data_i;
              bit_q   <= BCW'(DW - 1);
              addr_q  <= addr_q + 1'b1;
              state_q <= ST_MARK;
            end
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign msg_addr_o = addr_q[AW-1:0];
  assign ir_o       = (state_q == ST_MARK) && shift_q[DW-1];
  assign busy_o     = run;
  assign status_o   = status_q;
endmodule

// File: rtl/ir_frame_tx_chk.sv
`timescale 1ns/1ps
module ir_frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic rx_active_i,
  input logic ir_o,
  input logic busy_o,
  input logic status_o
);
  p_idle_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ir_o);

  p_busy_fall_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !$past(ir_o));

  p_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !rx_active_i) |=> (busy_o && !status_o));

  p_reject_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> (status_o && busy_o || status_o && !$past(ir_o)));

  p_reject_rx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && rx_active_i) |=> (status_o && !busy_o));

  p_reset_low_r8: assert property (@(posedge clk_i) !rst_ni |-> (!ir_o && !busy_o));
endmodule

bind ir_frame_tx ir_frame_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .rx_active_i (rx_active_i),
  .ir_o        (ir_o),
  .busy_o      (busy_o),
  .status_o    (status_o)
);

// File: tb/ir_frame_tx_bench.sv
`timescale 1ns/1ps
module ir_frame_tx_bench;
  typedef struct packed {
    logic [7:0] smp, mark, space, gap, rep, b0, b1;
  } vec_t;

  localparam int NV = 5;
  // smp mark space gap rep b0 b1
  localparam vec_t VEC [NV] = '{
    '{8'd0, 8'd1, 8'd1, 8'd2, 8'd1, 8'hA5, 8'h00},  // R2 R3 R5 basic
    '{8'd1, 8'd2, 8'd1, 8'd1, 8'd2, 8'h80, 8'h03},  // R1 R6 two bytes, repeat
    '{8'd0, 8'd1, 8'd2, 8'd1, 8'd0, 8'hFF, 8'h00},  // R6 repeat 0 -> 1
    '{8'd0, 8'd0, 8'd0, 8'd0, 8'd1, 8'h40, 8'h00},  // R11 zero lengths
    '{8'd0, 8'd1, 8'd1, 8'd3, 8'd2, 8'h00, 8'h11}   // R3 empty frame
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [2:0] cfg_sel_i = '0;
  logic [7:0] cfg_wdata_i = '0;
  logic       start_i = 1'b0;
  logic       rx_active_i = 1'b0;
  logic [3:0] msg_addr_o;
  logic [7:0] msg_data_i;
  logic       ir_o, busy_o, status_o;
  logic [7:0] mem [16];

  int n_tests = 0, n_fail = 0;
  int c_s, c_mark, c_space, c_gap, c_rep;
  int m_idx, m_act, m_exp;

  always #2.5 clk = ~clk;
  assign msg_data_i = mem[msg_addr_o];

  ir_frame_tx u_ir_frame_tx (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .start_i(start_i), .rx_active_i(rx_active_i),
    .msg_addr_o(msg_addr_o), .msg_data_i(msg_data_i), .ir_o(ir_o),
    .busy_o(busy_o), .status_o(status_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = 3'(sel); cfg_wdata_i = 8'(val);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic set_cfg(input int s, input int mk, input int sp, input int g, input int r);
    wr(0, s); wr(1, mk); wr(2, sp); wr(3, g); wr(4, r);
    c_s = s; c_mark = mk; c_space = sp; c_gap = g; c_rep = r;
  endtask

  function automatic int one(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int frame_total();
    int tl = 20 + 5 * c_s, tot = 0;
    for (int r = 0; r < one(c_rep); r++) begin
      for (int bi = 0; bi < 16; bi++) begin
        if (mem[bi] == 8'h00) break;
        tot += 8 * (one(c_mark) + one(c_space)) * tl;
      end
      tot += one(c_gap) * tl;
    end
    return tot;
  endfunction

  task automatic seg(input logic lvl, input int len, input int poke, inout int idx, inout int bad);
    for (int k = 0; k < len; k++) begin
      if (ir_o !== lvl || busy_o !== 1'b1) begin
        if (bad == 0) begin m_idx = idx; m_act = 2 * busy_o + ir_o; m_exp = 2 + lvl; end
        bad++;
      end
      if (idx == poke) begin
        start_i = 1'b1; cfg_we_i = 1'b1; cfg_sel_i = 3'd1; cfg_wdata_i = 8'd7;
      end else begin
        start_i = 1'b0; cfg_we_i = 1'b0;
      end
      @(negedge clk);
      idx++;
    end
  endtask

  // Starts a send and compares ir_o/busy_o every cycle against the expected slots
  task automatic run_frame(input int poke, input string tag, input string req);
    int tl = 20 + 5 * c_s, idx = 0, bad = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int r = 0; r < one(c_rep); r++) begin
      for (int bi = 0; bi < 16; bi++) begin
        if (mem[bi] == 8'h00) break;
        for (int b = 7; b >= 0; b--) begin
          seg(mem[bi][b], one(c_mark) * tl, poke, idx, bad);
          seg(1'b0, one(c_space) * tl, poke, idx, bad);
        end
      end
      seg(1'b0, one(c_gap) * tl, poke, idx, bad);
    end
    start_i = 1'b0; cfg_we_i = 1'b0;
    if (bad != 0) $display("  %s first mismatch at cycle %0d (busy*2+ir)", tag, m_idx);
    chk(bad == 0, req, {tag, " waveform busy*2+ir"}, bad == 0 ? 0 : m_act, bad == 0 ? 0 : m_exp);
    chk(busy_o == 1'b0 && ir_o == 1'b0, "R8", {tag, " idle after last gap"}, 2 * busy_o + ir_o, 0);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    chk(ir_o == 0 && busy_o == 0, "R8", "in reset busy*2+ir", 2 * busy_o + ir_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ir_o == 0 && busy_o == 0 && status_o == 0, "R8", "after reset", 4 * status_o + 2 * busy_o + ir_o, 0);

    // R9 reset defaults: sample 2, mark 20, space 20, gap 100, repeat 3
    c_s = 2; c_mark = 20; c_space = 20; c_gap = 100; c_rep = 3;
    mem[0] = 8'h01;
    run_frame(-1, "defaults", "R9");
    chk(status_o == 0, "R7", "status after accept", status_o, 0);

    for (int v = 0; v < NV; v++) begin
      clear_mem();
      mem[0] = VEC[v].b0; mem[1] = VEC[v].b1;
      set_cfg(VEC[v].smp, VEC[v].mark, VEC[v].space, VEC[v].gap, VEC[v].rep);
      run_frame(-1, $sformatf("vec%0d", v), "R2");
    end

    // R7 R10: start and mark write mid-frame are ignored
    clear_mem(); mem[0] = 8'hA5;
    set_cfg(0, 1, 1, 2, 1);
    run_frame(30, "midpoke", "R10");
    chk(status_o == 1, "R7", "status after busy start", status_o, 1);

    // R7: start in the final gap cycle is refused
    set_cfg(0, 1, 1, 2, 1);
    run_frame(frame_total() - 1, "endpoke", "R7");
    chk(status_o == 1, "R7", "status after last-cycle start", status_o, 1);
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && ir_o == 0, "R7", "no send after last-cycle start", 2 * busy_o + ir_o, 0);

    // R7: receiver activity blocks a start
    @(negedge clk); start_i = 1'b0; rx_active_i = 1'b1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; rx_active_i = 1'b0;
    chk(busy_o == 0 && status_o == 1, "R7", "rx active refuse busy*2+status", 2 * busy_o + status_o, 1);

    // R4: full buffer without terminator
    for (int i = 0; i < 16; i++) mem[i] = 8'h81;
    set_cfg(0, 1, 1, 1, 1);
    run_frame(-1, "fullbuf", "R4");
    chk(status_o == 0, "R7", "status cleared by accept", status_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule